// File: doc/BRIEF.md
# Key-Gated Reset Line Bank

This block drives a bank of reset outputs for other subsystems. Each output is controlled by one bit of a single 32-bit register, and that register sits at a fixed offset on a simple register bus. Software sets a bit to hold the matching reset line asserted and clears the bit to release it. A line stays where the last accepted write put it, so a reset pulse takes two writes: one that sets the bit and one that clears it.

A write reaches the bank only if its top byte carries the unlock key. Any other write at the offset is discarded, and so is a write to another address. A read at the offset returns the present line states in the low bits, with zeros above them, so software can read the bank, change one bit and write it back with the key. The number of lines is a parameter that may be up to 23. Write bits at or above that count have no effect.

Top module: `srst_ctrl`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, every reset line is deasserted (0) after that edge.
- R2: A write with `bus_wr`=1, `bus_addr` equal to `BANK_ADDR` (default 0x18) and `bus_wdata[31:24]` equal to `UNLOCK_KEY` (default 0x88) sets `rst_lines[n]` to `bus_wdata[n]` for every line n. The outputs change on the first rising edge after the write is presented.
- R3: A write to `BANK_ADDR` whose `bus_wdata[31:24]` differs from `UNLOCK_KEY` leaves every line unchanged.
- R4: A write to any address other than `BANK_ADDR` leaves every line unchanged, whatever key it carries.
- R5: When no accepted write occurs, every line holds its value from one clock to the next.
- R6: Write data bits from position `NUM_LINES` up to bit 23 have no effect on any line.
- R7: When `bus_rd`=1 and `bus_addr` equals `BANK_ADDR`, `bus_rdata` returns the line states in bits `[NUM_LINES-1:0]`, and all higher bits, including the key byte, read as 0. The read path is combinational.
- R8: When `bus_rd`=0, or when the address does not match, `bus_rdata` is all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | 32 | Write data: key in [31:24], line controls in the low bits |
| bus_rdata | output | 32 | Read data, zero unless a read hits the bank |
| rst_lines | output | NUM_LINES | Registered reset lines, 1 = asserted |

## Verification
The assertions assume that the bus inputs are stable and known at each rising edge, and that `bus_wr` is high for exactly the cycle of the access. The bench changes every input on the falling edge and drops the strobe after one cycle, so every access is a clean single-cycle write or read. The sweeps use a six-line configuration. They try every value of the line bits with varied junk in the ignored bits, every wrong key byte, and every address other than the bank offset, so that each gating condition is covered completely.

// File: rtl/srst_pkg.sv
package srst_pkg;

    localparam int unsigned WORD_W  = 32;
    localparam int unsigned KEY_LSB = 24;
    localparam int unsigned KEY_W   = WORD_W - KEY_LSB;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [KEY_W-1:0]  key_t;

endpackage

// File: rtl/srst_decode.sv
module srst_decode #(
    parameter int unsigned      ADDR_W     = 8,
    parameter logic [ADDR_W-1:0] BANK_ADDR = 8'h18,
    parameter srst_pkg::key_t   UNLOCK_KEY = 8'h88
) (
    input  logic              wr,
    input  logic              rd,
    input  logic [ADDR_W-1:0] addr,
    input  srst_pkg::key_t    key,
    output logic              wr_accept,
    output logic              rd_hit
);

    logic addr_match;

    always_comb begin
        addr_match = (addr == BANK_ADDR);
        wr_accept  = wr && addr_match && (key == UNLOCK_KEY);
        rd_hit     = rd && addr_match;
    end

endmodule

// File: rtl/srst_bank.sv
module srst_bank #(
    parameter int unsigned NUM_LINES = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  logic [NUM_LINES-1:0] load_val,
    output logic [NUM_LINES-1:0] lines
);

    typedef struct packed {
        logic [NUM_LINES-1:0] lines;
    } bank_state_t;

    bank_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (load) begin
            state_d.lines = load_val;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign lines = state_q.lines;

endmodule

// File: rtl/srst_rdmux.sv
module srst_rdmux #(
    parameter int unsigned NUM_LINES = 16
) (
    input  logic                 hit,
    input  logic [NUM_LINES-1:0] lines,
    output srst_pkg::word_t      rdata
);

    localparam int unsigned PAD_W = srst_pkg::WORD_W - NUM_LINES;

    always_comb begin
        rdata = '0;
        if (hit) begin
            rdata = {{PAD_W{1'b0}}, lines};
        end
    end

endmodule

// File: rtl/srst_ctrl.sv
module srst_ctrl #(
    parameter int unsigned       NUM_LINES  = 16,
    parameter int unsigned       ADDR_W     = 8,
    parameter logic [ADDR_W-1:0] BANK_ADDR  = 8'h18,
    parameter logic [7:0]        UNLOCK_KEY = 8'h88
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_wr,
    input  logic                 bus_rd,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    output logic [NUM_LINES-1:0] rst_lines
);

    localparam int unsigned KEY_LSB = srst_pkg::KEY_LSB;

    logic wr_accept;
    logic rd_hit;
    logic unused_wdata_bits;

    // data bits between the lines and the key byte never reach the bank (R6)
    assign unused_wdata_bits = ^{1'b0, bus_wdata[KEY_LSB-1:NUM_LINES]};

    srst_decode #(
        .ADDR_W    (ADDR_W),
        .BANK_ADDR (BANK_ADDR),
        .UNLOCK_KEY(UNLOCK_KEY)
    ) u_decode (
        .wr       (bus_wr),
        .rd       (bus_rd),
        .addr     (bus_addr),
        .key      (bus_wdata[31:KEY_LSB]),
        .wr_accept(wr_accept),
        .rd_hit   (rd_hit)
    );

    srst_bank #(
        .NUM_LINES(NUM_LINES)
    ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (wr_accept),
        .load_val(bus_wdata[NUM_LINES-1:0]),
        .lines   (rst_lines)
    );

    srst_rdmux #(
        .NUM_LINES(NUM_LINES)
    ) u_rdmux (
        .hit  (rd_hit),
        .lines(rst_lines),
        .rdata(bus_rdata)
    );

endmodule

// File: rtl/srst_ctrl_chk.sv
module srst_ctrl_chk #(
    parameter int unsigned       NUM_LINES  = 16,
    parameter int unsigned       ADDR_W     = 8,
    parameter logic [ADDR_W-1:0] BANK_ADDR  = 8'h18,
    parameter logic [7:0]        UNLOCK_KEY = 8'h88
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 bus_wr,
    input logic                 bus_rd,
    input logic [ADDR_W-1:0]    bus_addr,
    input logic [31:0]          bus_wdata,
    input logic [31:0]          bus_rdata,
    input logic [NUM_LINES-1:0] rst_lines
);

    // R1
    reset_clears_chk: assert property (@(posedge clk)
        !rst_n |=> rst_lines == '0);

    // R2
    keyed_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == BANK_ADDR && bus_wdata[31:24] == UNLOCK_KEY)
        |=> rst_lines == $past(bus_wdata[NUM_LINES-1:0]));

    // R3
    bad_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == BANK_ADDR && bus_wdata[31:24] != UNLOCK_KEY)
        |=> $stable(rst_lines));

    // R4
    other_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr != BANK_ADDR) |=> $stable(rst_lines));

    // R5
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |=> $stable(rst_lines));

    // R7
    read_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == BANK_ADDR)
        |-> bus_rdata == {{(32-NUM_LINES){1'b0}}, rst_lines});

    // R8
    read_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_rd || bus_addr != BANK_ADDR) |-> bus_rdata == 32'h0);

endmodule

bind srst_ctrl srst_ctrl_chk #(
    .NUM_LINES (NUM_LINES),
    .ADDR_W    (ADDR_W),
    .BANK_ADDR (BANK_ADDR),
    .UNLOCK_KEY(UNLOCK_KEY)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_wr   (bus_wr),
    .bus_rd   (bus_rd),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .rst_lines(rst_lines)
);

// File: tb/srst_ctrl_test.sv
`timescale 1ns/1ps
module srst_ctrl_test;

    localparam int unsigned N    = 6;
    localparam logic [7:0]  OFS  = 8'h18;
    localparam logic [7:0]  KEY  = 8'h88;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_wr = 1'b0;
    logic         bus_rd = 1'b0;
    logic [7:0]   bus_addr = '0;
    logic [31:0]  bus_wdata = '0;
    logic [31:0]  bus_rdata;
    logic [N-1:0] rst_lines;

    int checks = 0;
    int fails  = 0;
    logic [N-1:0] model = '0;

    always #10 clk = ~clk;

    srst_ctrl #(
        .NUM_LINES (N),
        .ADDR_W    (8),
        .BANK_ADDR (OFS),
        .UNLOCK_KEY(KEY)
    ) uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_wr   (bus_wr),
        .bus_rd   (bus_rd),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .rst_lines(rst_lines)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr    = 1'b1;
        bus_addr  = a;
        bus_wdata = d;
        @(negedge clk);
        bus_wr    = 1'b0;
        bus_wdata = '0;
    endtask

    task automatic do_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd   = 1'b1;
        bus_addr = a;
        #1;
        d = bus_rdata;
        bus_rd = 1'b0;
    endtask

    initial begin
        #(20 * 200000);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        repeat (3) @(negedge clk);
        // R1: lines cleared under reset
        check("R1", 32'(rst_lines), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", 32'(rst_lines), 32'h0);

        // R2, R6, R7: every line pattern with junk in the ignored bits
        for (int v = 0; v < (1 << N); v++) begin
            logic [23:0] low;
            low = 24'((v * 24'h2f5b1) << N) | 24'(v);
            do_write(OFS, {KEY, low});
            model = N'(v);
            check("R2/R6", 32'(rst_lines), 32'(model));
            do_read(OFS, rd);
            check("R7", rd, 32'(model));
        end

        // R3: every wrong key byte at the bank offset
        for (int k = 0; k < 256; k++) begin
            if (8'(k) != KEY) begin
                do_write(OFS, {8'(k), 24'h0});
                check("R3", 32'(rst_lines), 32'(model));
            end
        end

        // R4 and R8: every other address, correct key
        for (int a = 0; a < 256; a++) begin
            if (8'(a) != OFS) begin
                do_write(8'(a), {KEY, 24'h0});
                check("R4", 32'(rst_lines), 32'(model));
                if ((a % 16) == 3) begin
                    do_read(8'(a), rd);
                    check("R8", rd, 32'h0);
                end
            end
        end

        // R8: no read strobe at the bank offset
        @(negedge clk);
        bus_addr = OFS;
        #1;
        check("R8", bus_rdata, 32'h0);

        // R5: idle cycles hold the lines
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            check("R5", 32'(rst_lines), 32'(model));
        end

        // R2: pulse one line by set then clear
        do_write(OFS, {KEY, 24'h000004});
        check("R2", 32'(rst_lines), 32'h4);
        do_write(OFS, {KEY, 24'h000000});
        check("R2", 32'(rst_lines), 32'h0);

        // R7: read-modify-write of one bit
        do_write(OFS, {KEY, 24'h000021});
        do_read(OFS, rd);
        do_write(OFS, {KEY, rd[23:0] | 24'h2});
        check("R7", 32'(rst_lines), 32'h23);

        // R1: reset during operation
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1", 32'(rst_lines), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", 32'(rst_lines), 32'h0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule